// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block collects level-sensitive interrupt requests from up to 64 devices on a shared expansion bus and turns them into the 16 inputs of a legacy interrupt controller. Each request arrives as a one-cycle report carrying the device's registration index, its slot number, the interrupt pin it uses (A to D) and the new level. The block rotates the pin by the slot number to pick one of four shared interrupt groups. This spreads devices that all use pin A across different groups. Each device's level is then remembered as one bit in that group's bitmap.

Four byte-wide routing registers, one per group, name the legacy IRQ that the group drives. Any value of 16 or more leaves the group unrouted, and every routing register resets to 0x80, so nothing is routed after reset. Each IRQ output is the OR of every group routed to it, so two groups may share one line. A 16-bit trigger-mode register, written as two bytes, marks which legacy IRQs are level-triggered. Its value is presented on a separate output for the interrupt controller. The outputs are registered and follow a level report or a register write at the next clock edge.

Top module: `irq_router`

## Requirements
- R1: After reset `irq_out` is all zero, `irq_level_mode` is all zero, the routing registers at `cfg_addr` 0 to 3 read 0x80, and the trigger-mode bytes at `cfg_addr` 4 and 5 read 0x00.
- R2: A report with pin p (0 = A to 3 = D) and slot s sets the bit of group (p + s) mod 4, so only that group's routed IRQ can change.
- R3: Each group holds one bit per device index (0 to 63). A report with level 0 clears only that device's bit, so the group stays active while any other device in it is high.
- R4: When a group's routing register holds a value v below 16, `irq_out[v]` is high exactly when some device bit in that group is set.
- R5: A routing register value of 16 or more (bits 7:4 not all zero) disconnects its group, and no output is driven by it.
- R6: When two groups are routed to the same IRQ, that output is the OR of both groups.
- R7: `irq_out` changes at the first clock edge after a level report or routing write is presented, and not before that edge.
- R8: Byte 4 holds trigger-mode bits for IRQ 0 to 7 (bit n gives IRQ n) and byte 5 holds IRQ 8 to 15 (bit n gives IRQ 8+n). A set bit means level-triggered and appears on `irq_level_mode` after the write's edge. Both bytes read back what was written.
- R9: Writes to `cfg_addr` 6 and 7 change no register and no output. Reads of those addresses return 0x00.
- R10: Rewriting a group's routing register moves its activity from the old IRQ line to the new one at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_valid | input | 1 | A level report is present this cycle |
| lvl_dev | input | 6 | Registration index of the reporting device |
| lvl_slot | input | 5 | Slot number of the reporting device |
| lvl_pin | input | 2 | Interrupt pin used, 0 = A to 3 = D |
| lvl_value | input | 1 | New level of that device's interrupt |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 to 3 routing, 4 and 5 trigger mode |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr`, combinational |
| irq_out | output | 16 | Legacy IRQ request lines |
| irq_level_mode | output | 16 | Trigger mode per IRQ, 1 = level |

## Verification
The case that is hardest to reach from the ports is a group that stays active while its members drop out one by one, on a line that a second group also drives. Reaching it takes devices whose different slot and pin pairs rotate into the same group, including the boundary indices 0 and 63 and slot 31. Those devices are then released in an order where the shared line must stay high through each step. The vector table builds this state step by step. It then disconnects the group with an out-of-range routing value and moves it to another line.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
    localparam int GRP_CNT   = 4;
    localparam int GRP_W     = 2;
    localparam int ROUTE_W   = 8;
    localparam int ADDR_W    = 3;
    localparam logic [ROUTE_W-1:0] ROUTE_RST = 8'h80;

    typedef logic [ROUTE_W-1:0] route_t;

    // rotate the pin by the low slot bits to pick the shared group
    function automatic logic [GRP_W-1:0] swizzle(input logic [1:0] pin,
                                                 input logic [4:0] slot);
        return pin + slot[GRP_W-1:0];
    endfunction
endpackage

// File: rtl/irq_grp_bitmap.sv
module irq_grp_bitmap
    import irq_rt_pkg::*;
#(
    parameter int NUM_DEV = 64,
    localparam int IDX_W = $clog2(NUM_DEV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [IDX_W-1:0]   evt_idx,
    input  logic [GRP_W-1:0]   evt_grp,
    input  logic               evt_level,
    output logic [GRP_CNT-1:0] grp_any_nxt
);
    logic [NUM_DEV-1:0] bits_q [GRP_CNT];
    logic [NUM_DEV-1:0] bits_d [GRP_CNT];

    always_comb begin
        for (int g = 0; g < GRP_CNT; g++) bits_d[g] = bits_q[g];
        if (evt_valid) bits_d[evt_grp][evt_idx] = evt_level;
    end

    always_ff @(posedge clk) begin
        for (int g = 0; g < GRP_CNT; g++) begin
            if (!rst_n) bits_q[g] <= '0;
            else        bits_q[g] <= bits_d[g];
        end
    end

    for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
        assign grp_any_nxt[g] = |bits_d[g];

        AST_OTHER_GRP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_valid && evt_grp != GRP_W'(g)) |=> $stable(bits_q[g]))
            else $error("group %0d changed by a report for another group", g); // R2
        AST_IDLE_GRP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_valid |=> $stable(bits_q[g]))
            else $error("group %0d changed with no report", g); // R3
        AST_ONE_BIT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
            evt_valid |=> ($countones(bits_q[g] ^ $past(bits_q[g])) <= 1))
            else $error("more than one device bit changed in group %0d", g); // R3
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_rt_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    localparam int MODE_BYTES = NUM_IRQ / 8,
    localparam int MODE_BASE  = GRP_CNT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [ROUTE_W-1:0]     wdata,
    output logic [ROUTE_W-1:0]     rdata,
    output route_t [GRP_CNT-1:0]   route_nxt,
    output logic [NUM_IRQ-1:0]     mode_q
);
    route_t [GRP_CNT-1:0] route_q;
    logic [NUM_IRQ-1:0]   mode_d;

    always_comb begin
        route_nxt = route_q;
        if (wr_en && addr < ADDR_W'(GRP_CNT))
            route_nxt[addr[GRP_W-1:0]] = wdata;
    end

    for (genvar b = 0; b < MODE_BYTES; b++) begin : g_mode
        assign mode_d[b*8 +: 8] = (wr_en && addr == ADDR_W'(MODE_BASE + b))
                                  ? wdata : mode_q[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= {GRP_CNT{ROUTE_RST}};
            mode_q  <= '0;
        end else begin
            route_q <= route_nxt;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < ADDR_W'(GRP_CNT)) rdata = route_q[addr[GRP_W-1:0]];
        for (int b = 0; b < MODE_BYTES; b++)
            if (addr == ADDR_W'(MODE_BASE + b)) rdata = mode_q[b*8 +: 8];
    end

    AST_REGS_HELD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(route_q) && $stable(mode_q)))
        else $error("register changed without a write"); // R9
    AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= ADDR_W'(MODE_BASE + MODE_BYTES)) |=> ($stable(route_q) && $stable(mode_q)))
        else $error("write to unmapped address changed a register"); // R9
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge
    import irq_rt_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    localparam int IRQ_W = $clog2(NUM_IRQ)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [GRP_CNT-1:0]   grp_any,
    input  route_t [GRP_CNT-1:0] route,
    output logic [NUM_IRQ-1:0]   irq_q
);
    logic [NUM_IRQ-1:0] irq_d;
    logic [GRP_CNT-1:0] grp_on;

    for (genvar g = 0; g < GRP_CNT; g++) begin : g_en
        assign grp_on[g] = route[g] < ROUTE_W'(NUM_IRQ);
    end

    always_comb begin
        irq_d = '0;
        for (int i = 0; i < NUM_IRQ; i++)
            for (int g = 0; g < GRP_CNT; g++)
                if (grp_on[g] && grp_any[g] && route[g][IRQ_W-1:0] == IRQ_W'(i))
                    irq_d[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    AST_AT_MOST_GRP_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_q) <= GRP_CNT)
        else $error("more IRQ lines active than groups exist"); // R6
    AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_on == '0) |=> (irq_q == '0))
        else $error("IRQ active with every group disconnected"); // R5
    AST_IDLE_GRPS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_any == '0) |=> (irq_q == '0))
        else $error("IRQ active with every group empty"); // R4
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_rt_pkg::*;
#(
    parameter int NUM_DEV = 64,
    parameter int NUM_IRQ = 16,
    localparam int IDX_W = $clog2(NUM_DEV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lvl_valid,
    input  logic [IDX_W-1:0]   lvl_dev,
    input  logic [4:0]         lvl_slot,
    input  logic [1:0]         lvl_pin,
    input  logic               lvl_value,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic [NUM_IRQ-1:0] irq_out,
    output logic [NUM_IRQ-1:0] irq_level_mode
);
    logic [GRP_W-1:0]     evt_grp;
    logic [GRP_CNT-1:0]   grp_any_nxt;
    route_t [GRP_CNT-1:0] route_nxt;

    assign evt_grp = swizzle(lvl_pin, lvl_slot);

    irq_grp_bitmap #(.NUM_DEV(NUM_DEV)) u_bitmap (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_valid   (lvl_valid),
        .evt_idx     (lvl_dev),
        .evt_grp     (evt_grp),
        .evt_level   (lvl_value),
        .grp_any_nxt (grp_any_nxt)
    );

    irq_route_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .route_nxt (route_nxt),
        .mode_q    (irq_level_mode)
    );

    irq_route_merge #(.NUM_IRQ(NUM_IRQ)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_any (grp_any_nxt),
        .route   (route_nxt),
        .irq_q   (irq_out)
    );

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && irq_level_mode == '0))
        else $error("outputs not cleared by reset"); // R1
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lvl_valid = 1'b0;
    logic [5:0] lvl_dev = '0;
    logic [4:0] lvl_slot = '0;
    logic [1:0] lvl_pin = '0;
    logic lvl_value = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [15:0] irq_out;
    logic [15:0] irq_level_mode;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    irq_router u_irq_router (
        .clk(clk), .rst_n(rst_n),
        .lvl_valid(lvl_valid), .lvl_dev(lvl_dev), .lvl_slot(lvl_slot),
        .lvl_pin(lvl_pin), .lvl_value(lvl_value),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_out(irq_out), .irq_level_mode(irq_level_mode)
    );

    // vector: [41] op (1 = register write) [40:35] dev [34:30] slot [29:28] pin
    //         [27] level [26:24] addr [23:16] data [15:0] expected irq_out
    localparam int NV = 17;
    localparam logic [41:0] VEC [NV] = '{
        {1'b1, 6'd0,  5'd0,  2'd0, 1'b0, 3'd0, 8'h05, 16'h0000},
        {1'b0, 6'd3,  5'd1,  2'd3, 1'b1, 3'd0, 8'h00, 16'h0020},
        {1'b0, 6'd7,  5'd2,  2'd2, 1'b1, 3'd0, 8'h00, 16'h0020},
        {1'b0, 6'd3,  5'd1,  2'd3, 1'b0, 3'd0, 8'h00, 16'h0020},
        {1'b0, 6'd7,  5'd2,  2'd2, 1'b0, 3'd0, 8'h00, 16'h0000},
        {1'b1, 6'd0,  5'd0,  2'd0, 1'b0, 3'd2, 8'h09, 16'h0000},
        {1'b0, 6'd10, 5'd0,  2'd2, 1'b1, 3'd0, 8'h00, 16'h0200},
        {1'b0, 6'd63, 5'd31, 2'd3, 1'b1, 3'd0, 8'h00, 16'h0200},
        {1'b1, 6'd0,  5'd0,  2'd0, 1'b0, 3'd1, 8'h09, 16'h0200},
        {1'b0, 6'd0,  5'd0,  2'd1, 1'b1, 3'd0, 8'h00, 16'h0200},
        {1'b0, 6'd10, 5'd0,  2'd2, 1'b0, 3'd0, 8'h00, 16'h0200},
        {1'b0, 6'd63, 5'd31, 2'd3, 1'b0, 3'd0, 8'h00, 16'h0200},
        {1'b1, 6'd0,  5'd0,  2'd0, 1'b0, 3'd1, 8'h10, 16'h0000},
        {1'b1, 6'd0,  5'd0,  2'd0, 1'b0, 3'd1, 8'h0F, 16'h8000},
        {1'b1, 6'd0,  5'd0,  2'd0, 1'b0, 3'd3, 8'h00, 16'h8000},
        {1'b0, 6'd20, 5'd5,  2'd2, 1'b1, 3'd0, 8'h00, 16'h8001},
        {1'b1, 6'd0,  5'd0,  2'd0, 1'b0, 3'd3, 8'hFF, 16'h8000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_evt(input logic [5:0] idx, input logic [4:0] s, input logic [1:0] p,
                          input logic l);
        @(negedge clk);
        lvl_valid = 1'b1; lvl_dev = idx; lvl_slot = s; lvl_pin = p; lvl_value = l;
        @(negedge clk);
        lvl_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_out", irq_out, 16'h0000);
        chk("R1 level mode", irq_level_mode, 16'h0000);
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), d); chk("R1 route reset", {8'h00, d}, 16'h0080);
        end
        rd(3'd4, d); chk("R1 mode byte 4", {8'h00, d}, 16'h0000);
        rd(3'd5, d); chk("R1 mode byte 5", {8'h00, d}, 16'h0000);

        // R2 R3 R4 R5 R6 R10 vector walk
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][41]) do_write(VEC[k][26:24], VEC[k][23:16]);
            else do_evt(VEC[k][40:35], VEC[k][34:30], VEC[k][29:28], VEC[k][27]);
            chk($sformatf("R2 R3 R4 R5 R6 R10 vector %0d", k), irq_out, VEC[k][15:0]);
        end

        // R7 route write takes effect at the edge, not before
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 3'd3; cfg_wdata = 8'h02;
        #1 chk("R7 before edge (route)", irq_out, 16'h8000);
        @(negedge clk);
        cfg_wr = 1'b0;
        chk("R7 after edge (route)", irq_out, 16'h8004);

        // R7 level report takes effect at the edge, not before
        @(negedge clk);
        lvl_valid = 1'b1; lvl_dev = 6'd0; lvl_slot = 5'd0; lvl_pin = 2'd1; lvl_value = 1'b0;
        #1 chk("R7 before edge (level)", irq_out, 16'h8004);
        @(negedge clk);
        lvl_valid = 1'b0;
        chk("R7 after edge (level)", irq_out, 16'h0004);

        // R8 trigger mode bytes
        do_write(3'd4, 8'h21);
        chk("R8 low byte", irq_level_mode, 16'h0021);
        do_write(3'd5, 8'h80);
        chk("R8 high byte", irq_level_mode, 16'h8021);
        rd(3'd4, d); chk("R8 readback 4", {8'h00, d}, 16'h0021);
        rd(3'd5, d); chk("R8 readback 5", {8'h00, d}, 16'h0080);

        // R9 unmapped writes ignored
        do_write(3'd6, 8'hFF);
        do_write(3'd7, 8'h00);
        chk("R9 irq_out", irq_out, 16'h0004);
        chk("R9 level mode", irq_level_mode, 16'h8021);
        rd(3'd0, d); chk("R9 route 0", {8'h00, d}, 16'h0005);
        rd(3'd1, d); chk("R9 route 1", {8'h00, d}, 16'h000F);
        rd(3'd2, d); chk("R9 route 2", {8'h00, d}, 16'h0009);
        rd(3'd3, d); chk("R9 route 3", {8'h00, d}, 16'h0002);
        rd(3'd6, d); chk("R9 read 6", {8'h00, d}, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule